// File: doc/BRIEF.md
# Sequenced-Unlock Watchdog Timer

This block is a watchdog timer that runs on a slow tick clock and is set up through a small register bus. Software places a start value in a load register and then writes a new value to a trigger register, which copies the start value into an up-counter. The timer is armed only by a fixed two-word write sequence and disarmed only by a second two-word sequence. While the timer is armed the counter climbs, once per tick or once per 2^n ticks when the prescaler is on. If the counter wraps from all ones to zero, the block sends a single-cycle reset pulse and latches a flag that software can read and clear.

Writes to the control, load, trigger and start/stop registers are posted. Each one takes effect a fixed number of tick cycles after the bus write. Until then, its own busy bit in a status register stays high, and software polls that bit before it writes the same register again. This stands in for a crossing from a faster bus clock, which is not modelled here. While the timer is armed, configuration writes are locked out, so changing the timeout safely means disarm, reconfigure, then rearm.

Top module: `wdog_seq`

## Requirements
- R1: After reset the timer is disarmed. Control, load, counter, flag and the pending register all read 0, and `wdt_reset_o` is low. Register addresses: 0 control, 1 load, 2 counter (read only), 3 trigger, 4 start/stop, 5 pending status, 6 reset flag.
- R2: A write to control, load, trigger or start/stop takes effect POST_DLY cycles after the edge that samples it. Its pending bit is high from that edge until the commit edge. The pending bits are: bit 0 control, bit 2 load, bit 3 trigger, bit 4 start/stop. A second write to a register whose bit is still high is dropped.
- R3: A committed 0x0000BBBB to start/stop, followed directly by a committed 0x00004444, arms the timer.
- R4: A committed 0x0000AAAA to start/stop, followed directly by a committed 0x00005555, disarms the timer.
- R5: Any other word committed to start/stop after a first word sends the sequence back to idle, so a later matching second word has no effect.
- R6: The counter moves only while the timer is armed, and it moves up by one per prescaler step.
- R7: Control bit 5 enables the prescaler and bits 4:2 hold the exponent n. With the prescaler on, the counter steps once every 2^n cycles. With it off, the counter steps every cycle.
- R8: A committed trigger value that differs from the last committed trigger value copies the load register into the counter. A repeat of the same value is ignored. The trigger holds 0 after reset.
- R9: Control or load writes that commit while the timer is armed are ignored.
- R10: A wrap from all ones to zero while armed gives a one-cycle high pulse on `wdt_reset_o` and sets bit 0 of the flag register. Writing 1 to that bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| wdt_reset_o | output | 1 | One-cycle reset pulse on overflow |

## Verification
The prescaler is tested against a table of settings: off, on with exponents 0, 1, 3 and 7. Each setting is measured over a whole number of step periods, so an error in the exponent decode or the divider shows up as a wrong counter delta. The sequence machine gets the valid arm and disarm pairs, and also a first word followed by a stray word and then the matching word, which must leave the timer disarmed. Trigger writes with a repeated value and with a new value show whether reload depends on a change or on any write. Back-to-back writes show whether the busy lockout works. A load write while armed shows whether the configuration lock works. The overflow run counts the high cycles of the reset pulse and checks the set and clear of the flag.

// File: rtl/wdog_pkg.sv
// Shared constants for the sequenced-unlock watchdog: register addresses,
// magic words, control field positions and sequence states.
package wdog_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LOAD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRIG  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SS    = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd6;

    // Posting slots, in generate order
    localparam int NSLOT   = 4;
    localparam int S_CTRL  = 0;
    localparam int S_LOAD  = 1;
    localparam int S_TRIG  = 2;
    localparam int S_SS    = 3;

    localparam logic [15:0] ARM_FIRST  = 16'hBBBB;
    localparam logic [15:0] ARM_SECOND = 16'h4444;
    localparam logic [15:0] DIS_FIRST  = 16'hAAAA;
    localparam logic [15:0] DIS_SECOND = 16'h5555;

    localparam int PRE_EN_BIT  = 5;
    localparam int PRE_EXP_LSB = 2;
    localparam int EXP_W       = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARM_HALF,
        SEQ_DIS_HALF
    } seq_state_t;
endpackage

// File: rtl/wdog_post_slot.sv
// One posted-write slot. It captures a bus write, holds it for POST_DLY
// cycles, then raises fire for one cycle with the data.
// Assumes POST_DLY >= 1. Writes that arrive while busy are dropped.
module wdog_post_slot #(
    parameter int DATA_W   = 32,
    parameter int POST_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              fire,
    output logic [DATA_W-1:0] data
);
    localparam int DLY_W = $clog2(POST_DLY + 1);

    logic [DLY_W-1:0] left_q;

    assign fire = busy && (left_q == '0);

    // Capture a write, count down the posting delay, retire on fire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            left_q <= '0;
            data   <= '0;
        end else if (!busy) begin
            if (wr) begin
                busy   <= 1'b1;
                left_q <= DLY_W'(POST_DLY - 1);
                data   <= wdata;
            end
        end else if (fire) begin
            busy <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_unlock_fsm.sv
// Start/stop sequence machine. Committed words move it between idle and the
// two half-sequence states. A matching second word arms or disarms the timer.
// Assumes commit is a one-cycle pulse per committed write.
module wdog_unlock_fsm
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] word,
    output logic              armed
);
    seq_state_t st_q;
    logic is_arm1, is_arm2, is_dis1, is_dis2;

    assign is_arm1 = (word == DATA_W'(ARM_FIRST));
    assign is_arm2 = (word == DATA_W'(ARM_SECOND));
    assign is_dis1 = (word == DATA_W'(DIS_FIRST));
    assign is_dis2 = (word == DATA_W'(DIS_SECOND));

    // Advance the sequence and update the armed state on each committed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            armed <= 1'b0;
        end else if (commit) begin
            if (is_arm1) begin
                st_q <= SEQ_ARM_HALF;
            end else if (is_dis1) begin
                st_q <= SEQ_DIS_HALF;
            end else if (st_q == SEQ_ARM_HALF && is_arm2) begin
                armed <= 1'b1;
                st_q  <= SEQ_IDLE;
            end else if (st_q == SEQ_DIS_HALF && is_dis2) begin
                armed <= 1'b0;
                st_q  <= SEQ_IDLE;
            end else begin
                st_q <= SEQ_IDLE;
            end
        end
    end
endmodule

// File: rtl/wdog_prescale.sv
// Step generator. With the prescaler off it steps every cycle while run is
// high. With it on, it steps once every 2^exp cycles. Idle while not running.
module wdog_prescale #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] pre_exp,
    output logic             step
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    // Terminal count 2^exp - 1 as a mask of exp low ones
    always_comb lim = ~({DIV_W{1'b1}} << pre_exp);

    assign step = run && (!pre_en || (div_q == lim));

    // Divider counter, cleared on each step and while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run || step) div_q <= '0;
        else                         div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/wdog_counter.sv
// Watchdog up-counter. Reload takes priority over a step. A step from all
// ones wraps to zero and raises ovf for exactly one cycle after the wrap.
module wdog_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    // Count, reload and flag the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (reload) begin
                cnt <= load_val;
            end else if (step) begin
                cnt <= cnt + 1'b1;
                ovf <= &cnt;
            end
        end
    end
endmodule

// File: rtl/wdog_seq.sv
// Sequenced-unlock watchdog top. Holds the register file, the posted-write
// slots, the sequence machine, the prescaler, the counter and the reset flag.
// Assumes the bus and the timer share the tick clock. Posting is a fixed delay.
module wdog_seq
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int POST_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset_o
);
    localparam logic [ADDR_W-1:0] SLOT_ADDR [NSLOT] = '{A_CTRL, A_LOAD, A_TRIG, A_SS};

    logic [NSLOT-1:0]  s_busy, s_fire;
    logic [DATA_W-1:0] s_data [NSLOT];

    logic [DATA_W-1:0] ctrl_q, load_q, trig_q, cnt_q;
    logic              armed, step, reload, flag_q;
    logic [DATA_W-1:0] pend_vec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        wdog_post_slot #(.DATA_W(DATA_W), .POST_DLY(POST_DLY)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_we && (bus_addr == SLOT_ADDR[g])),
            .wdata (bus_wdata),
            .busy  (s_busy[g]),
            .fire  (s_fire[g]),
            .data  (s_data[g])
        );
    end

    // Configuration registers, locked while armed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (s_fire[S_CTRL] && !armed) ctrl_q <= s_data[S_CTRL];
            if (s_fire[S_LOAD] && !armed) load_q <= s_data[S_LOAD];
        end
    end

    assign reload = s_fire[S_TRIG] && (s_data[S_TRIG] != trig_q);

    // Last committed trigger value, kept to detect a change
    always_ff @(posedge clk) begin
        if (!rst_n)      trig_q <= '0;
        else if (reload) trig_q <= s_data[S_TRIG];
    end

    wdog_unlock_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (s_fire[S_SS]),
        .word   (s_data[S_SS]),
        .armed  (armed)
    );

    wdog_prescale #(.EXP_W(EXP_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (armed),
        .pre_en  (ctrl_q[PRE_EN_BIT]),
        .pre_exp (ctrl_q[PRE_EXP_LSB +: EXP_W]),
        .step    (step)
    );

    wdog_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .load_val (load_q),
        .step     (step),
        .cnt      (cnt_q),
        .ovf      (wdt_reset_o)
    );

    // Reset-source flag: set on overflow, cleared by writing 1 to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                                        flag_q <= 1'b0;
        else if (wdt_reset_o)                              flag_q <= 1'b1;
        else if (bus_we && bus_addr == A_FLAG && bus_wdata[0]) flag_q <= 1'b0;
    end

    // Pending-status layout: bit 0 ctrl, bit 2 load, bit 3 trigger, bit 4 start/stop
    always_comb begin
        pend_vec    = '0;
        pend_vec[0] = s_busy[S_CTRL];
        pend_vec[2] = s_busy[S_LOAD];
        pend_vec[3] = s_busy[S_TRIG];
        pend_vec[4] = s_busy[S_SS];
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_LOAD:  bus_rdata = load_q;
            A_COUNT: bus_rdata = cnt_q;
            A_TRIG:  bus_rdata = trig_q;
            A_PEND:  bus_rdata = pend_vec;
            A_FLAG:  bus_rdata = DATA_W'(flag_q);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_seq_chk.sv
// Property checker for wdog_seq, attached with bind. It observes the armed
// state, the reload strobe, the counter, the load register, the flag and the
// pending vector.
module wdog_seq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              armed,
    input logic              reload,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] load_q,
    input logic              wdt_reset_o,
    input logic              flag,
    input logic [DATA_W-1:0] pend
);
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> !wdt_reset_o);

    assert_pulse_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |-> $past(armed));

    assert_flag_after_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset_o |=> flag);

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !reload) |=> $stable(cnt));

    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(load_q));

    assert_pend_unused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] == 1'b0) && (pend[DATA_W-1:5] == '0));
endmodule

bind wdog_seq wdog_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed),
    .reload      (reload),
    .cnt         (cnt_q),
    .load_q      (load_q),
    .wdt_reset_o (wdt_reset_o),
    .flag        (flag_q),
    .pend        (pend_vec)
);

// File: tb/wdog_seq_bench.sv
module wdog_seq_bench;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          wdt_reset_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] trig_val = 32'd100;

    wdog_seq u_wdog_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_reset_o(wdt_reset_o)
    );

    always #5 clk = ~clk;

    // Prescaler table: {pre_en, exp[2:0], wait cycles[15:0], expected delta[15:0]}
    localparam int NV = 5;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 3'd0, 16'd10,  16'd10},
        {1'b1, 3'd0, 16'd8,   16'd8},
        {1'b1, 3'd1, 16'd16,  16'd8},
        {1'b1, 3'd3, 16'd32,  16'd4},
        {1'b1, 3'd7, 16'd256, 16'd2}
    };

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // Single write, then wait until it has committed
    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic arm();
        wr(3'd4, 32'hBBBB); wr(3'd4, 32'h4444);
    endtask

    task automatic disarm();
        wr(3'd4, 32'hAAAA); wr(3'd4, 32'h5555);
    endtask

    task automatic new_trig();
        trig_val = trig_val + 1;
        wr(3'd3, trig_val);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v, v0, v1;
        int pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reg after reset", v, '0);
        end
        chk("R1 reset output low", {31'b0, wdt_reset_o}, 32'd0);

        // R2: pending bit for load write and commit timing
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h11;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 3'd5;
        #1 chk("R2 load busy bit 2 set", bus_rdata, 32'h4);
        @(negedge clk); #1 chk("R2 load busy still set", bus_rdata, 32'h4);
        @(negedge clk); #1 chk("R2 load busy cleared at commit", bus_rdata, 32'h0);
        rd(3'd1, v); chk("R2 load committed", v, 32'h11);

        // R2: second write while busy is dropped
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h22;
        @(negedge clk);
        bus_wdata = 32'h33;
        @(negedge clk);
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd1, v); chk("R2 write during busy dropped", v, 32'h22);

        // R8: trigger reload on change only
        wr(3'd1, 32'h100);
        new_trig();
        rd(3'd2, v); chk("R8 new trigger reloads", v, 32'h100);
        wr(3'd1, 32'h200);
        wr(3'd3, trig_val);
        rd(3'd2, v); chk("R8 repeated trigger ignored", v, 32'h100);
        new_trig();
        rd(3'd2, v); chk("R8 changed trigger reloads", v, 32'h200);

        // R6: counter holds while disarmed
        repeat (10) @(negedge clk);
        rd(3'd2, v); chk("R6 counter holds disarmed", v, 32'h200);

        // R5: broken arm sequence leaves timer disarmed
        wr(3'd4, 32'hBBBB); wr(3'd4, 32'h1234); wr(3'd4, 32'h4444);
        repeat (10) @(negedge clk);
        rd(3'd2, v); chk("R5 broken sequence stays disarmed", v, 32'h200);

        // R3 / R7: prescaler table, each run armed with the arm sequence
        for (int i = 0; i < NV; i++) begin
            disarm();
            wr(3'd0, {26'b0, VEC[i][35], VEC[i][34:32], 2'b00});
            arm();
            rd(3'd2, v0);
            repeat (int'(VEC[i][31:16]) - 1) @(negedge clk);
            rd(3'd2, v1);
            chk($sformatf("R7 R3 prescale entry %0d delta", i), v1 - v0, {16'b0, VEC[i][15:0]});
        end

        // R9: load write while armed is ignored
        wr(3'd1, 32'h777);
        rd(3'd1, v); chk("R9 load locked while armed", v, 32'h200);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R9 ctrl locked while armed", v, 32'h3C);

        // R4: disarm stops the counter
        disarm();
        rd(3'd2, v0);
        repeat (300) @(negedge clk);
        rd(3'd2, v1);
        chk("R4 disarm stops counter", v1, v0);

        // R10: overflow pulse and flag
        wr(3'd0, 32'h0);
        wr(3'd1, 32'hFFFF_FFF0);
        new_trig();
        arm();
        pulses = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (wdt_reset_o) pulses++;
        end
        chk("R10 reset pulse one cycle", pulses, 1);
        rd(3'd6, v); chk("R10 flag set", v, 32'h1);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(3'd6, v); chk("R10 flag cleared by write 1", v, 32'h0);
        disarm();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule